// File: doc/BRIEF.md
# Four-Channel Auto-Reloading DMA Controller

This block is a four-channel DMA engine that software programs through a small word-addressed register bus. Each channel keeps a working address counter for a source device (A) and for a destination device (B), and a working byte-length counter. Each of the three counters has a reload register beside it. A channel is started either by its hardware request line or by a software request bit in its control register. Once started, it issues one-byte transfers on a request/acknowledge bus-master port. The external fabric carries out each beat from the A address to the B address and acknowledges it.

When a block finishes, the channel can reload all three counters from their reload registers and keep going, so that it fills the same memory area again and again with no software help. The first block completion sets a terminal-count flag. A later completion that arrives while that flag is still set sets an overrun flag. Each flag drives a per-channel level interrupt when its enable bit is set.

When more than one channel is ready, the lowest-numbered one is served first. A beat that has been granted always runs to its acknowledge.

Top module: `dma_autoinit_ctrl`

## Requirements
- R1: After reset, every register of every channel reads zero, `bm_req` is low and `irq` is all zero.
- R2: Register address `reg_addr` = {channel[1:0], select[2:0]}. The select values are: 0 A counter, 1 A reload, 2 B counter, 3 B reload, 4 length counter, 5 length reload, 6 control, 7 status. Counter and reload registers are 21 bits wide, and bits 31..21 read as zero. `reg_wen[0]` writes bits 15..0 and `reg_wen[1]` writes bits 31..16; the half that is not enabled keeps its value.
- R3: Each acknowledged beat adds one to both address counters of the active channel and takes one from its length counter.
- R4: Control bit 0 enables the channel and control bit 2 is the software request. A channel asks for service only when it is enabled, its length counter is nonzero, and either its `dreq` line or its software request bit is set. A disabled channel is never granted.
- R5: Among the channels asking for service, the lowest-numbered one is granted. While `bm_req` is high and `bm_ack` is low, `bm_req` and `bm_chan` hold their values.
- R6: Control bit 1 selects auto-initialize. In that mode, the beat that brings the length counter to zero reloads the A, B and length counters from their reload registers.
- R7: With auto-initialize off, the beat that brings the length counter to zero clears the enable bit. The address counters keep their advanced values and no further beats are issued.
- R8: At a block end, status bit 0 (terminal count) is set if it was clear. If it was already set, status bit 1 (overrun) is set instead. The overrun bit never rises unless terminal count was set on the cycle before.
- R9: `irq[n]` is high while status bit 0 is set together with control bit 3, or while status bit 1 is set together with control bit 4. Writing 1 to a status bit clears it, and the status bits change only at a block end or through a status write.
- R10: After an auto-initialize reload, the channel keeps issuing beats from the reloaded addresses for as long as its request stays active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 5 | Register word address {channel, select} |
| reg_wen | input | 2 | Half-word write enables (bit 0 low half, bit 1 high half) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| dreq | input | 4 | Hardware transfer request, one per channel |
| bm_req | output | 1 | Bus-master beat request |
| bm_ack | input | 1 | Beat completed by the fabric |
| bm_chan | output | 2 | Channel that owns the current beat |
| bm_addr_a | output | 21 | Source (device A) byte address |
| bm_addr_b | output | 21 | Destination (device B) byte address |
| irq | output | 4 | Per-channel level interrupt |

## Verification
The checker watches every cycle that a pending beat keeps its request and channel until it is acknowledged, and that each new grant goes to a channel that was asking and that no lower-numbered channel was asking. It also checks that overrun rises only on top of a set terminal-count bit, and that terminal count clears only after a register write. The counter arithmetic, the exact reload values, the disabling at the end of a single block, the repetition of the same address range, the half-word write masking and the interrupt levels for each combination of enables depend on programmed values. Only the bench's directed scenarios can show these.

// File: rtl/dma_autoinit_pkg.sv
package dma_autoinit_pkg;

    typedef enum logic [2:0] {
        SEL_A_CNT   = 3'd0,
        SEL_A_RLD   = 3'd1,
        SEL_B_CNT   = 3'd2,
        SEL_B_RLD   = 3'd3,
        SEL_LEN_CNT = 3'd4,
        SEL_LEN_RLD = 3'd5,
        SEL_CTL     = 3'd6,
        SEL_STAT    = 3'd7
    } reg_sel_e;

    localparam int unsigned CTL_W    = 5;
    localparam int unsigned CTL_EN   = 0;
    localparam int unsigned CTL_AUTO = 1;
    localparam int unsigned CTL_SWRQ = 2;
    localparam int unsigned CTL_TCIE = 3;
    localparam int unsigned CTL_OVIE = 4;

endpackage

// File: rtl/dma_autoinit_chan.sv
module dma_autoinit_chan
    import dma_autoinit_pkg::*;
#(
    parameter int unsigned REG_W = 21,
    parameter int unsigned DW    = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_hit,
    input  logic [1:0]       wr_half,
    input  reg_sel_e         sel,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata,
    input  logic             hw_req,
    input  logic             beat_done,
    output logic             want,
    output logic [REG_W-1:0] addr_a,
    output logic [REG_W-1:0] addr_b,
    output logic             irq,
    output logic             tc,
    output logic             ovr
);

    typedef struct packed {
        logic [REG_W-1:0] a_cnt;
        logic [REG_W-1:0] a_rld;
        logic [REG_W-1:0] b_cnt;
        logic [REG_W-1:0] b_rld;
        logic [REG_W-1:0] len_cnt;
        logic [REG_W-1:0] len_rld;
        logic [CTL_W-1:0] ctl;
        logic             tc;
        logic             ovr;
    } chan_st_t;

    chan_st_t s_d, s_q;
    logic     last_beat;
    logic     set_tc, set_ovr, clr_tc, clr_ovr;

    function automatic logic [DW-1:0] merge(input logic [DW-1:0] old,
                                            input logic [DW-1:0] nw,
                                            input logic [1:0]    half);
        logic [DW-1:0] r;
        r = old;
        if (half[0]) r[15:0]    = nw[15:0];
        if (half[1]) r[DW-1:16] = nw[DW-1:16];
        return r;
    endfunction

    always_comb begin
        s_d       = s_q;
        last_beat = beat_done && (s_q.len_cnt <= REG_W'(1));
        set_tc    = last_beat && !s_q.tc;
        set_ovr   = last_beat &&  s_q.tc;
        clr_tc    = wr_hit && (sel == SEL_STAT) && wr_half[0] && wdata[0];
        clr_ovr   = wr_hit && (sel == SEL_STAT) && wr_half[0] && wdata[1];

        if (beat_done) begin
            s_d.a_cnt   = s_q.a_cnt + REG_W'(1);
            s_d.b_cnt   = s_q.b_cnt + REG_W'(1);
            s_d.len_cnt = s_q.len_cnt - REG_W'(1);
            if (last_beat) begin
                if (s_q.ctl[CTL_AUTO]) begin
                    s_d.a_cnt   = s_q.a_rld;
                    s_d.b_cnt   = s_q.b_rld;
                    s_d.len_cnt = s_q.len_rld;
                end else begin
                    s_d.ctl[CTL_EN] = 1'b0;
                end
            end
        end

        if (wr_hit) begin
            unique case (sel)
                SEL_A_CNT:   s_d.a_cnt   = REG_W'(merge(DW'(s_q.a_cnt),   wdata, wr_half));
                SEL_A_RLD:   s_d.a_rld   = REG_W'(merge(DW'(s_q.a_rld),   wdata, wr_half));
                SEL_B_CNT:   s_d.b_cnt   = REG_W'(merge(DW'(s_q.b_cnt),   wdata, wr_half));
                SEL_B_RLD:   s_d.b_rld   = REG_W'(merge(DW'(s_q.b_rld),   wdata, wr_half));
                SEL_LEN_CNT: s_d.len_cnt = REG_W'(merge(DW'(s_q.len_cnt), wdata, wr_half));
                SEL_LEN_RLD: s_d.len_rld = REG_W'(merge(DW'(s_q.len_rld), wdata, wr_half));
                SEL_CTL:     s_d.ctl     = CTL_W'(merge(DW'(s_q.ctl),     wdata, wr_half));
                default:     ;
            endcase
        end

        s_d.tc  = (s_q.tc  && !clr_tc)  || set_tc;
        s_d.ovr = (s_q.ovr && !clr_ovr) || set_ovr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        unique case (sel)
            SEL_A_CNT:   rdata = DW'(s_q.a_cnt);
            SEL_A_RLD:   rdata = DW'(s_q.a_rld);
            SEL_B_CNT:   rdata = DW'(s_q.b_cnt);
            SEL_B_RLD:   rdata = DW'(s_q.b_rld);
            SEL_LEN_CNT: rdata = DW'(s_q.len_cnt);
            SEL_LEN_RLD: rdata = DW'(s_q.len_rld);
            SEL_CTL:     rdata = DW'(s_q.ctl);
            default:     rdata = DW'({s_q.ovr, s_q.tc});
        endcase
    end

    assign want   = s_q.ctl[CTL_EN] && (hw_req || s_q.ctl[CTL_SWRQ]) && (s_q.len_cnt != '0);
    assign addr_a = s_q.a_cnt;
    assign addr_b = s_q.b_cnt;
    assign tc     = s_q.tc;
    assign ovr    = s_q.ovr;
    assign irq    = (s_q.tc && s_q.ctl[CTL_TCIE]) || (s_q.ovr && s_q.ctl[CTL_OVIE]);

endmodule

// File: rtl/dma_autoinit_arb.sv
module dma_autoinit_arb #(
    parameter int unsigned NUM_CH = 4,
    localparam int unsigned CH_W  = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] want,
    input  logic              ack,
    output logic              busy,
    output logic [CH_W-1:0]   ch,
    output logic [NUM_CH-1:0] done
);

    typedef struct packed {
        logic            busy;
        logic [CH_W-1:0] ch;
    } arb_st_t;

    arb_st_t a_d, a_q;

    always_comb begin
        a_d = a_q;
        if (a_q.busy) begin
            if (ack) a_d.busy = 1'b0;
        end else if (|want) begin
            a_d.busy = 1'b1;
            for (int i = NUM_CH - 1; i >= 0; i--) begin
                if (want[i]) a_d.ch = CH_W'(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) a_q <= '0;
        else        a_q <= a_d;
    end

    assign busy = a_q.busy;
    assign ch   = a_q.ch;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_done
        assign done[g] = a_q.busy && ack && (a_q.ch == CH_W'(g));
    end

endmodule

// File: rtl/dma_autoinit_ctrl.sv
module dma_autoinit_ctrl
    import dma_autoinit_pkg::*;
#(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned REG_W  = 21,
    parameter int unsigned DW     = 32,
    localparam int unsigned CH_W  = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CH_W+2:0]   reg_addr,
    input  logic [1:0]        reg_wen,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    input  logic [NUM_CH-1:0] dreq,
    output logic              bm_req,
    input  logic              bm_ack,
    output logic [CH_W-1:0]   bm_chan,
    output logic [REG_W-1:0]  bm_addr_a,
    output logic [REG_W-1:0]  bm_addr_b,
    output logic [NUM_CH-1:0] irq
);

    logic [CH_W-1:0]   reg_ch;
    reg_sel_e          reg_sel;
    logic [NUM_CH-1:0] ch_want, ch_done, ch_tc, ch_ovr;
    logic [DW-1:0]     ch_rdata [NUM_CH];
    logic [REG_W-1:0]  ch_addr_a [NUM_CH];
    logic [REG_W-1:0]  ch_addr_b [NUM_CH];

    assign reg_ch  = reg_addr[CH_W+2:3];
    assign reg_sel = reg_sel_e'(reg_addr[2:0]);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        dma_autoinit_chan #(.REG_W(REG_W), .DW(DW)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_hit    ((|reg_wen) && (reg_ch == CH_W'(g))),
            .wr_half   (reg_wen),
            .sel       (reg_sel),
            .wdata     (reg_wdata),
            .rdata     (ch_rdata[g]),
            .hw_req    (dreq[g]),
            .beat_done (ch_done[g]),
            .want      (ch_want[g]),
            .addr_a    (ch_addr_a[g]),
            .addr_b    (ch_addr_b[g]),
            .irq       (irq[g]),
            .tc        (ch_tc[g]),
            .ovr       (ch_ovr[g])
        );
    end

    dma_autoinit_arb #(.NUM_CH(NUM_CH)) u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .want  (ch_want),
        .ack   (bm_ack),
        .busy  (bm_req),
        .ch    (bm_chan),
        .done  (ch_done)
    );

    assign reg_rdata = ch_rdata[reg_ch];
    assign bm_addr_a = ch_addr_a[bm_chan];
    assign bm_addr_b = ch_addr_b[bm_chan];

endmodule

// File: rtl/dma_autoinit_chk.sv
module dma_autoinit_chk #(
    parameter int unsigned NUM_CH = 4,
    localparam int unsigned CH_W  = $clog2(NUM_CH)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        reg_wen,
    input logic              bm_req,
    input logic              bm_ack,
    input logic [CH_W-1:0]   bm_chan,
    input logic [NUM_CH-1:0] want,
    input logic [NUM_CH-1:0] tc,
    input logic [NUM_CH-1:0] ovr
);

    logic [NUM_CH-1:0] want_q;
    logic [NUM_CH-1:0] lower_mask;

    always_ff @(posedge clk) begin
        if (!rst_n) want_q <= '0;
        else        want_q <= want;
    end

    always_comb begin
        for (int i = 0; i < NUM_CH; i++) lower_mask[i] = (CH_W'(i) < bm_chan);
    end

    // R5
    gnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bm_req && !bm_ack |=> bm_req && $stable(bm_chan));

    // R5
    prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bm_req) |-> ((want_q & lower_mask) == '0));

    // R4
    req_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bm_req) |-> want_q[bm_chan]);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_stat
        // R8
        ovr_after_tc_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ovr[g]) |-> $past(tc[g]));
        // R9
        tc_clr_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(tc[g]) |-> $past(reg_wen[0]));
    end

endmodule

bind dma_autoinit_ctrl dma_autoinit_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .reg_wen (reg_wen),
    .bm_req  (bm_req),
    .bm_ack  (bm_ack),
    .bm_chan (bm_chan),
    .want    (ch_want),
    .tc      (ch_tc),
    .ovr     (ch_ovr)
);

// File: tb/dma_autoinit_ctrl_test.sv
module dma_autoinit_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [1:0]  reg_wen = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  dreq = '0;
    logic        bm_req;
    logic        bm_ack = 1'b0;
    logic [1:0]  bm_chan;
    logic [20:0] bm_addr_a, bm_addr_b;
    logic [3:0]  irq;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    dma_autoinit_ctrl uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wen(reg_wen),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dreq(dreq),
        .bm_req(bm_req), .bm_ack(bm_ack), .bm_chan(bm_chan),
        .bm_addr_a(bm_addr_a), .bm_addr_b(bm_addr_b), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input int ch, input int sel, input logic [31:0] d, input logic [1:0] en = 2'b11);
        reg_addr  = 5'({ch[1:0], sel[2:0]});
        reg_wdata = d;
        reg_wen   = en;
        @(negedge clk);
        reg_wen   = 2'b00;
    endtask

    task automatic rd_chk(input string tag, input int ch, input int sel, input logic [31:0] exp);
        reg_addr = 5'({ch[1:0], sel[2:0]});
        #1;
        check(tag, reg_rdata, exp);
    endtask

    task automatic serve(input string tag, input int ch, input logic [20:0] a, input logic [20:0] b);
        int n = 0;
        while (!bm_req && n < 50) begin
            @(negedge clk);
            n++;
        end
        check({tag, " req"}, 32'(bm_req), 32'd1);
        check({tag, " chan"}, 32'(bm_chan), 32'(ch));
        check({tag, " addr_a"}, 32'(bm_addr_a), 32'(a));
        check({tag, " addr_b"}, 32'(bm_addr_b), 32'(b));
        bm_ack = 1'b1;
        @(negedge clk);
        bm_ack = 1'b0;
    endtask

    task automatic t_reset;
        for (int c = 0; c < 4; c++)
            for (int s = 0; s < 8; s++)
                rd_chk("R1 register zero", c, s, 32'd0);
        check("R1 bm_req low", 32'(bm_req), 32'd0);
        check("R1 irq low", 32'(irq), 32'd0);
    endtask

    task automatic t_width;
        wr(0, 1, 32'hFFFF_FFFF);
        rd_chk("R2 upper bits zero", 0, 1, 32'h001F_FFFF);
        wr(0, 1, 32'h0000_5678, 2'b01);
        rd_chk("R2 low half write", 0, 1, 32'h001F_5678);
        wr(0, 1, 32'h0003_0000, 2'b10);
        rd_chk("R2 high half write", 0, 1, 32'h0003_5678);
        wr(0, 1, 32'h0);
    endtask

    task automatic t_single_block;
        wr(1, 0, 32'h100);
        wr(1, 2, 32'h2000);
        wr(1, 4, 32'd3);
        wr(1, 6, 32'h5);
        serve("R4 sw req beat0", 1, 21'h100, 21'h2000);
        serve("R3 beat1", 1, 21'h101, 21'h2001);
        serve("R3 beat2", 1, 21'h102, 21'h2002);
        rd_chk("R3 len at zero", 1, 4, 32'd0);
        rd_chk("R7 A kept advanced", 1, 0, 32'h103);
        rd_chk("R7 enable cleared", 1, 6, 32'h4);
        rd_chk("R8 tc set", 1, 7, 32'h1);
        check("R9 irq off without enable", 32'(irq[1]), 32'd0);
        repeat (5) @(negedge clk);
        check("R7 no further beats", 32'(bm_req), 32'd0);
        wr(1, 6, 32'h8);
        check("R9 irq on tc enable", 32'(irq[1]), 32'd1);
        wr(1, 7, 32'h1);
        rd_chk("R9 w1c clears tc", 1, 7, 32'h0);
        check("R9 irq drops", 32'(irq[1]), 32'd0);
    endtask

    task automatic t_auto;
        wr(2, 0, 32'h10);
        wr(2, 1, 32'h10);
        wr(2, 2, 32'h80);
        wr(2, 3, 32'h80);
        wr(2, 4, 32'd2);
        wr(2, 5, 32'd2);
        wr(2, 6, 32'h1B);
        dreq[2] = 1'b1;
        serve("R4 hw req beat0", 2, 21'h10, 21'h80);
        serve("R3 auto beat1", 2, 21'h11, 21'h81);
        rd_chk("R8 first block tc", 2, 7, 32'h1);
        check("R9 irq tc", 32'(irq[2]), 32'd1);
        serve("R10 repeat beat0", 2, 21'h10, 21'h80);
        serve("R10 repeat beat1", 2, 21'h11, 21'h81);
        dreq[2] = 1'b0;
        rd_chk("R8 overrun on second block", 2, 7, 32'h3);
        rd_chk("R6 A reloaded", 2, 0, 32'h10);
        rd_chk("R6 B reloaded", 2, 2, 32'h80);
        rd_chk("R6 len reloaded", 2, 4, 32'd2);
        repeat (4) @(negedge clk);
        check("R4 idle without request", 32'(bm_req), 32'd0);
        wr(2, 7, 32'h2);
        rd_chk("R9 w1c ovr only", 2, 7, 32'h1);
        check("R9 irq held by tc", 32'(irq[2]), 32'd1);
        wr(2, 7, 32'h1);
        check("R9 irq cleared", 32'(irq[2]), 32'd0);
    endtask

    task automatic t_priority;
        wr(0, 0, 32'h500);
        wr(0, 2, 32'h600);
        wr(0, 4, 32'd1);
        wr(0, 6, 32'h1);
        wr(3, 0, 32'h700);
        wr(3, 2, 32'h780);
        wr(3, 4, 32'd1);
        wr(3, 6, 32'h1);
        dreq = 4'b1001;
        while (!bm_req) @(negedge clk);
        check("R5 lowest channel first", 32'(bm_chan), 32'd0);
        repeat (3) @(negedge clk);
        check("R5 request held", 32'(bm_req), 32'd1);
        check("R5 channel held", 32'(bm_chan), 32'd0);
        serve("R5 ch0 beat", 0, 21'h500, 21'h600);
        serve("R5 ch3 beat", 3, 21'h700, 21'h780);
        dreq = 4'b0000;
    endtask

    task automatic t_disabled;
        wr(1, 4, 32'd5);
        wr(1, 6, 32'h0);
        dreq[1] = 1'b1;
        repeat (8) @(negedge clk);
        check("R4 disabled never granted", 32'(bm_req), 32'd0);
        wr(1, 6, 32'h1);
        serve("R4 enabled then granted", 1, 21'h103, 21'h2003);
        dreq[1] = 1'b0;
    endtask

    initial begin
        #500000;
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_width;
        t_single_block;
        t_auto;
        t_priority;
        t_disabled;
        repeat (4) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule